// File: doc/BRIEF.md
# Trap Delegation Target Selector

This block keeps the machine-level delegation state for interrupts and synchronous exceptions. Each cycle it decides whether a trap is taken, which cause wins, and whether machine or supervisor mode handles it. Its inputs are the current privilege mode, the pending and enable interrupt vectors, the global machine and supervisor enables, and one exception strobe with its cause code.

The delegation registers and a software-owned supervisor timer pending bit sit behind a small register port. Writes take effect only while the hart runs in machine mode. The trap decision is combinational from the inputs and the stored state. The surrounding trap unit uses the strobe, cause and target mode to redirect the hart.

An interrupt's level comes from the pending line that raised it, not from the mode the hart is in. Machine-level interrupts can never be delegated. No trap is ever sent to a mode less privileged than the current one.

Top module: `trap_deleg_sel`

## Requirements
- R1: After reset all three register views read zero and, with all inputs low, no trap is signalled.
- R2: The interrupt delegation view (select 0) stores bits 0, 1, 4, 5, 8 and 9. Machine interrupt bits 3, 7 and 11 and all other bits read zero whatever is written, so writing all ones reads back 0x333.
- R3: The exception delegation view (select 1) stores bits 0 to 15, except bit 11 (environment call from machine mode), which reads zero, so writing all ones reads back 0xF7FF.
- R4: A register write made while the privilege input is not machine (encodings: user 0, supervisor 1, machine 3) changes no register.
- R5: Bit 5 of the pending input (supervisor timer) is ignored. The supervisor timer pending state is bit 5 of the software view (select 2), and it is written only from machine mode.
- R6: An interrupt that is not delegated is eligible when it is pending and enabled, and either the mode is below machine or the machine global enable is set.
- R7: A delegated supervisor interrupt (bit 1, 5 or 9) is eligible when it is pending and enabled, and either the mode is user or the mode is supervisor with the supervisor global enable set. It is never eligible in machine mode.
- R8: Among eligible interrupts the winner is chosen in this order, highest first: cause 11, 3, 7, 9, 1, 5.
- R9: A valid exception wins over any eligible interrupt. Trap is then signalled with the interrupt flag low and the exception's cause.
- R10: The target mode is supervisor (1) only when the chosen cause's delegation bit is set and the current mode is supervisor or user. Otherwise it is machine (3), and always machine when the current mode is machine.
- R11: An exception whose delegation bit is set goes to supervisor from user or supervisor mode, and to machine from machine mode.
- R12: The machine timer interrupt (cause 7) always targets machine mode, even after all ones are written to the interrupt delegation view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Current privilege mode (0 user, 1 supervisor, 3 machine) |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Register view: 0 interrupt delegation, 1 exception delegation, 2 software pending |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the selected view |
| irq_pend_i | input | IRQ_W | Interrupt pending lines |
| irq_en_i | input | IRQ_W | Interrupt enables |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| exc_valid_i | input | 1 | Synchronous exception present |
| exc_cause_i | input | CAUSE_W | Exception cause code |
| trap_o | output | 1 | A trap is taken this cycle |
| trap_irq_o | output | 1 | The trap is an interrupt |
| trap_cause_o | output | CAUSE_W | Chosen cause |
| trap_mode_o | output | 2 | Target mode (1 supervisor, 3 machine) |

## Verification
The selector is tried with one pending line at a time in every privilege mode, with the global enables toggled. This separates the machine eligibility rule from the delegated supervisor rule, and shows that machine mode blocks every downgrade. Pending sets are then thinned one line at a time, highest first, so each priority step is seen in isolation. Exception runs cover a delegated cause taken from each mode, and cause 11, which cannot be delegated. Runs with an exception and an interrupt together show that the exception wins. A pending timer bit driven on the hardware line, set against one set by software, shows which source is honoured.

// File: rtl/trap_deleg_pkg.sv
package trap_deleg_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] SEL_IDELEG = 2'd0;
  localparam logic [1:0] SEL_EDELEG = 2'd1;
  localparam logic [1:0] SEL_SWPEND = 2'd2;

  localparam int unsigned IRQ_USI = 0;
  localparam int unsigned IRQ_SSI = 1;
  localparam int unsigned IRQ_MSI = 3;
  localparam int unsigned IRQ_UTI = 4;
  localparam int unsigned IRQ_STI = 5;
  localparam int unsigned IRQ_MTI = 7;
  localparam int unsigned IRQ_UEI = 8;
  localparam int unsigned IRQ_SEI = 9;
  localparam int unsigned IRQ_MEI = 11;

  localparam int unsigned EXC_ECALL_M = 11;
  localparam int unsigned NUM_PRIO = 6;
endpackage

// File: rtl/deleg_regs.sv
module deleg_regs
  import trap_deleg_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IRQ_W = 16,
  parameter int unsigned EXC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       priv_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [XLEN-1:0]  rdata_o,
  output logic [IRQ_W-1:0] ideleg_o,
  output logic [EXC_W-1:0] edeleg_o,
  output logic             stip_o
);
  localparam logic [IRQ_W-1:0] IDELEG_MASK =
      (IRQ_W'(1) << IRQ_USI) | (IRQ_W'(1) << IRQ_SSI) | (IRQ_W'(1) << IRQ_UTI) |
      (IRQ_W'(1) << IRQ_STI) | (IRQ_W'(1) << IRQ_UEI) | (IRQ_W'(1) << IRQ_SEI);
  localparam logic [EXC_W-1:0] EDELEG_MASK = ~(EXC_W'(1) << EXC_ECALL_M);

  logic m_wr;
  assign m_wr = we_i && (priv_i == PRIV_M);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  // Only legal bits get storage; the rest are tied low.
  for (genvar i = 0; i < IRQ_W; i++) begin : g_ideleg
    if (IDELEG_MASK[i]) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           ideleg_o[i] <= 1'b0;
        else if (m_wr && sel_i == SEL_IDELEG)  ideleg_o[i] <= wdata_i[i];
      end
    end else begin : g_zero
      assign ideleg_o[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < EXC_W; i++) begin : g_edeleg
    if (EDELEG_MASK[i]) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           edeleg_o[i] <= 1'b0;
        else if (m_wr && sel_i == SEL_EDELEG)  edeleg_o[i] <= wdata_i[i];
      end
    end else begin : g_zero
      assign edeleg_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           stip_o <= 1'b0;
    else if (m_wr && sel_i == SEL_SWPEND)  stip_o <= wdata_i[IRQ_STI];
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_IDELEG: rdata_o = XLEN'(ideleg_o);
      SEL_EDELEG: rdata_o = XLEN'(edeleg_o);
      SEL_SWPEND: rdata_o[IRQ_STI] = stip_o;
      default:    rdata_o = '0;
    endcase
  end

  AST_LOW_PRIV_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && priv_i != PRIV_M) |=> ($stable(ideleg_o) && $stable(edeleg_o) && $stable(stip_o))); // R4

  AST_MACHINE_IRQ_NOT_DELEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_wr && sel_i == SEL_IDELEG) |=>
      (!ideleg_o[IRQ_MSI] && !ideleg_o[IRQ_MTI] && !ideleg_o[IRQ_MEI])); // R2

  AST_ECALL_M_NOT_DELEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_wr && sel_i == SEL_EDELEG) |=> !edeleg_o[EXC_ECALL_M]); // R3
endmodule

// File: rtl/irq_select.sv
module irq_select
  import trap_deleg_pkg::*;
#(
  parameter int unsigned IRQ_W   = 16,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         priv_i,
  input  logic [IRQ_W-1:0]   pend_i,
  input  logic [IRQ_W-1:0]   en_i,
  input  logic [IRQ_W-1:0]   deleg_i,
  input  logic               mie_i,
  input  logic               sie_i,
  output logic               valid_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               deleg_o
);
  // Index 0 is the highest priority.
  localparam int unsigned PRIO [NUM_PRIO]   = '{IRQ_MEI, IRQ_MSI, IRQ_MTI, IRQ_SEI, IRQ_SSI, IRQ_STI};
  localparam bit          IS_SUP [NUM_PRIO] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic [NUM_PRIO-1:0] elig;
  logic [NUM_PRIO-1:0] dlg;

  logic unused_bits;
  assign unused_bits = ^(pend_i & en_i & deleg_i);

  for (genvar i = 0; i < NUM_PRIO; i++) begin : g_elig
    logic live;
    assign live = pend_i[PRIO[i]] && en_i[PRIO[i]];
    if (IS_SUP[i]) begin : g_sup
      assign dlg[i] = deleg_i[PRIO[i]];
    end else begin : g_mach
      assign dlg[i] = 1'b0;
    end
    assign elig[i] = live && (dlg[i] ? ((priv_i == PRIV_U) || (priv_i == PRIV_S && sie_i))
                                     : ((priv_i != PRIV_M) || mie_i));
  end

  always_comb begin
    valid_o = 1'b0;
    cause_o = '0;
    deleg_o = 1'b0;
    for (int i = NUM_PRIO - 1; i >= 0; i--) begin
      if (elig[i]) begin
        valid_o = 1'b1;
        cause_o = CAUSE_W'(PRIO[i]);
        deleg_o = dlg[i];
      end
    end
  end

  AST_WINNER_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[cause_o] && en_i[cause_o])); // R6

  AST_NO_DELEG_IN_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && priv_i == PRIV_M) |-> !deleg_o); // R7
endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
  import trap_deleg_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IRQ_W   = 16,
  parameter int unsigned EXC_W   = 16,
  parameter int unsigned CAUSE_W = $clog2(EXC_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         priv_i,
  input  logic               csr_we_i,
  input  logic [1:0]         csr_sel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic [IRQ_W-1:0]   irq_pend_i,
  input  logic [IRQ_W-1:0]   irq_en_i,
  input  logic               mie_i,
  input  logic               sie_i,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  output logic               trap_o,
  output logic               trap_irq_o,
  output logic [CAUSE_W-1:0] trap_cause_o,
  output logic [1:0]         trap_mode_o
);
  logic [IRQ_W-1:0]   ideleg;
  logic [EXC_W-1:0]   edeleg;
  logic               stip;
  logic [IRQ_W-1:0]   pend_eff;
  logic               irq_valid;
  logic [CAUSE_W-1:0] irq_cause;
  logic               irq_deleg;
  logic               sel_deleg;

  deleg_regs #(.XLEN(XLEN), .IRQ_W(IRQ_W), .EXC_W(EXC_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .priv_i   (priv_i),
    .we_i     (csr_we_i),
    .sel_i    (csr_sel_i),
    .wdata_i  (csr_wdata_i),
    .rdata_o  (csr_rdata_o),
    .ideleg_o (ideleg),
    .edeleg_o (edeleg),
    .stip_o   (stip)
  );

  // Supervisor timer pending has no hardware source.
  always_comb begin
    pend_eff          = irq_pend_i;
    pend_eff[IRQ_STI] = stip;
  end

  irq_select #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) i_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .priv_i  (priv_i),
    .pend_i  (pend_eff),
    .en_i    (irq_en_i),
    .deleg_i (ideleg),
    .mie_i   (mie_i),
    .sie_i   (sie_i),
    .valid_o (irq_valid),
    .cause_o (irq_cause),
    .deleg_o (irq_deleg)
  );

  always_comb begin
    trap_o       = exc_valid_i || irq_valid;
    trap_irq_o   = !exc_valid_i && irq_valid;
    trap_cause_o = exc_valid_i ? exc_cause_i : irq_cause;
    sel_deleg    = exc_valid_i ? edeleg[exc_cause_i] : irq_deleg;
    trap_mode_o  = (trap_o && sel_deleg && priv_i != PRIV_M) ? PRIV_S : PRIV_M;
  end

  AST_NO_DOWNGRADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && priv_i == PRIV_M) |-> (trap_mode_o == PRIV_M)); // R10

  AST_EXC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> (trap_o && !trap_irq_o && trap_cause_o == exc_cause_i)); // R9

  AST_MTI_MACHINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_irq_o && trap_cause_o == CAUSE_W'(IRQ_MTI)) |-> (trap_mode_o == PRIV_M)); // R12

  AST_STIP_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_irq_o && trap_cause_o == CAUSE_W'(IRQ_STI)) |-> stip); // R5
endmodule

// File: tb/test_trap_deleg_sel.sv
module test_trap_deleg_sel;
  localparam int unsigned XLEN = 32;
  localparam int unsigned W    = 16;
  localparam int unsigned CW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      priv = 2'd3;
  logic            we = 1'b0;
  logic [1:0]      sel = 2'd0;
  logic [XLEN-1:0] wdata = '0;
  logic [XLEN-1:0] rdata;
  logic [W-1:0]    pend = '0;
  logic [W-1:0]    en = '0;
  logic            mie = 1'b0;
  logic            sie = 1'b0;
  logic            exc_v = 1'b0;
  logic [CW-1:0]   exc_c = '0;
  logic            trap;
  logic            trap_irq;
  logic [CW-1:0]   cause;
  logic [1:0]      mode;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  trap_deleg_sel i_trap_deleg_sel (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .csr_we_i(we), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .irq_pend_i(pend), .irq_en_i(en),
    .mie_i(mie), .sie_i(sie), .exc_valid_i(exc_v), .exc_cause_i(exc_c),
    .trap_o(trap), .trap_irq_o(trap_irq), .trap_cause_o(cause), .trap_mode_o(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [1:0] s, input logic [31:0] d);
    logic [1:0] keep;
    keep = priv;
    @(negedge clk);
    priv = p; sel = s; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; priv = keep;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    sel = s;
    #1 d = rdata;
  endtask

  // Settle combinational inputs, sample mid low phase.
  task automatic trap_chk(input string req, input logic t, input logic ti,
                          input logic [3:0] c, input logic [1:0] m);
    #2;
    chk({req, " trap"}, 32'(trap), 32'(t));
    if (t) begin
      chk({req, " irq"}, 32'(trap_irq), 32'(ti));
      chk({req, " cause"}, 32'(cause), 32'(c));
      chk({req, " mode"}, 32'(mode), 32'(m));
    end
  endtask

  task automatic clear_inputs();
    @(negedge clk);
    pend = '0; en = '0; mie = 0; sie = 0; exc_v = 0; exc_c = '0; priv = 2'd3;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 ideleg", d, 32'h0);
    rd(2'd1, d); chk("R1 edeleg", d, 32'h0);
    rd(2'd2, d); chk("R1 swpend", d, 32'h0);
    chk("R1 no trap", 32'(trap), 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd3, 2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 ideleg mask", d, 32'h333);
    wr(2'd3, 2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R3 edeleg mask", d, 32'hF7FF);
    wr(2'd1, 2'd0, 32'h0); rd(2'd0, d); chk("R4 S write ignored", d, 32'h333);
    wr(2'd0, 2'd1, 32'h0); rd(2'd1, d); chk("R4 U write ignored", d, 32'hF7FF);
    wr(2'd1, 2'd2, 32'h20); rd(2'd2, d); chk("R4 S swpend ignored", d, 32'h0);
    wr(2'd3, 2'd0, 32'h0); rd(2'd0, d); chk("R2 clear", d, 32'h0);
  endtask

  task automatic t_stip();
    logic [31:0] d;
    clear_inputs();
    priv = 2'd0; pend = 16'h0020; en = 16'hFFFF;
    trap_chk("R5 hw pin ignored", 0, 0, 0, 0);
    wr(2'd3, 2'd2, 32'h20);
    rd(2'd2, d); chk("R5 swpend read", d, 32'h20);
    pend = '0;
    trap_chk("R5 sw pending", 1, 1, 4'd5, 2'd3);
    wr(2'd3, 2'd2, 32'h0);
    trap_chk("R5 sw cleared", 0, 0, 0, 0);
  endtask

  task automatic t_m_elig();
    clear_inputs();
    pend = 16'h0080; en = 16'h0080;
    priv = 2'd3; mie = 0; trap_chk("R6 M mie=0", 0, 0, 0, 0);
    mie = 1;             trap_chk("R6 M mie=1", 1, 1, 4'd7, 2'd3);
    priv = 2'd1; mie = 0; trap_chk("R6 S below M", 1, 1, 4'd7, 2'd3);
    en = 16'h0; priv = 2'd0; trap_chk("R6 disabled", 0, 0, 0, 0);
  endtask

  task automatic t_s_deleg();
    clear_inputs();
    wr(2'd3, 2'd0, 32'h200);
    pend = 16'h0200; en = 16'h0200;
    priv = 2'd3; mie = 1; sie = 1; trap_chk("R7 blocked in M", 0, 0, 0, 0);
    priv = 2'd1; sie = 0; trap_chk("R7 S sie=0", 0, 0, 0, 0);
    sie = 1;              trap_chk("R7 S sie=1", 1, 1, 4'd9, 2'd1);
    priv = 2'd0; sie = 0; trap_chk("R7 U", 1, 1, 4'd9, 2'd1);
    wr(2'd3, 2'd0, 32'h0);
    priv = 2'd1; sie = 0; mie = 0; trap_chk("R10 undelegated to M", 1, 1, 4'd9, 2'd3);
  endtask

  task automatic t_prio();
    clear_inputs();
    priv = 2'd0; en = 16'hFFFF;
    pend = 16'h0A8A; trap_chk("R8 MEI top", 1, 1, 4'd11, 2'd3);
    pend = 16'h028A; trap_chk("R8 MSI next", 1, 1, 4'd3, 2'd3);
    pend = 16'h0282; trap_chk("R8 MTI next", 1, 1, 4'd7, 2'd3);
    pend = 16'h0202; trap_chk("R8 SEI next", 1, 1, 4'd9, 2'd3);
    wr(2'd3, 2'd2, 32'h20);
    pend = 16'h0002; trap_chk("R8 SSI over STI", 1, 1, 4'd1, 2'd3);
    pend = 16'h0000; trap_chk("R8 STI last", 1, 1, 4'd5, 2'd3);
    wr(2'd3, 2'd2, 32'h0);
  endtask

  task automatic t_exc();
    clear_inputs();
    wr(2'd3, 2'd1, 32'hFFFF);
    priv = 2'd0; en = 16'hFFFF; pend = 16'h0800;
    exc_v = 1; exc_c = 4'd2; trap_chk("R9 exc over irq", 1, 0, 4'd2, 2'd1);
    pend = '0;
    priv = 2'd1; trap_chk("R11 S delegated", 1, 0, 4'd2, 2'd1);
    priv = 2'd3; trap_chk("R11 M stays M", 1, 0, 4'd2, 2'd3);
    priv = 2'd0; exc_c = 4'd11; trap_chk("R3 cause11 to M", 1, 0, 4'd11, 2'd3);
    exc_c = 4'd8; trap_chk("R11 U delegated", 1, 0, 4'd8, 2'd1);
    wr(2'd3, 2'd1, 32'h0);
    trap_chk("R10 exc undelegated", 1, 0, 4'd8, 2'd3);
  endtask

  task automatic t_mti();
    clear_inputs();
    wr(2'd3, 2'd0, 32'hFFFF_FFFF);
    priv = 2'd0; pend = 16'h0080; en = 16'h0080; sie = 1;
    trap_chk("R12 MTI stays M", 1, 1, 4'd7, 2'd3);
    priv = 2'd1; trap_chk("R12 MTI from S", 1, 1, 4'd7, 2'd3);
    wr(2'd3, 2'd0, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_stip();
    t_m_elig();
    t_s_deleg();
    t_prio();
    t_exc();
    t_mti();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule